// File: doc/BRIEF.md
# Debounced Eight-Channel Input Serializer

This block is the device side of a digital input serializer. Eight input pins pass through a two-flop synchronizer and then a per-channel debounce filter. Two select pins choose the filter strength, and all channels share that choice. When the host pulls chip-select low, the filtered byte is captured into a shift register. The register is then clocked out most-significant bit first as an SPI slave in clock mode 0.

A word-size select input picks one of two frame sizes. The short frame carries the data byte only. The long frame carries the data byte followed by a status byte. The status byte holds a 5-bit CRC of the captured data and three alarm indicator bits taken from external pins. A serial input enters the far end of the shift register, so several instances can be chained with each one's output wired to the next one's input. The host then reads all the words in one transfer.

Every pin, including SCLK and chip-select, is sampled in the system clock domain. SCLK must therefore stay well below a quarter of the system clock rate.

Top module: `dser_top`

## Requirements
- R1: After reset the serial output is 0 and the filtered data byte is 0x00.
- R2: With `word_wide` low, one transfer returns 8 bits: filtered channel 7 first, down to channel 0.
- R3: With `word_wide` high, one transfer returns 16 bits: the data byte first, then the status byte.
- R4: Status byte layout: bits 7..3 hold the CRC, bit 2 holds `uv_alarm_n`, bit 1 holds `ot_alarm`, and bit 0 holds `uv_warn_n`, each copied as the pin level.
- R5: The CRC is computed over the 8 data bits, MSB first, with polynomial x^5+x^4+x^2+1 (low terms 5'b10101) and an initial value of 0.
- R6: Bits presented on `sdi` appear on `sdo` exactly one frame length later, in the same order.
- R7: With `flt_sel` = 2'b00 there is no filtering: a steady input change is captured within a few clocks.
- R8: With `flt_sel` = 2'b01, a channel changes only after its synchronized input has differed from the filtered value for `TICKS_SHORT` consecutive clocks. A shorter pulse is ignored.
- R9: With `flt_sel` = 2'b10, the same rule applies with `TICKS_MED` clocks.
- R10: With `flt_sel` = 2'b11, the same rule applies with `TICKS_LONG` clocks.
- R11: Data, status and frame size are fixed at the falling edge of chip-select. Changes to them during the transfer do not affect the word being shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_pins | input | 8 | Raw digital input channels |
| flt_sel | input | 2 | Debounce strength select |
| word_wide | input | 1 | 1: data+status frame, 0: data-only frame |
| ot_alarm | input | 1 | Overtemperature indicator, active high |
| uv_alarm_n | input | 1 | Undervoltage alarm indicator, active low |
| uv_warn_n | input | 1 | Undervoltage warning indicator, active low |
| cs_n | input | 1 | SPI chip-select, active low |
| sclk | input | 1 | SPI clock (mode 0) |
| sdi | input | 1 | Chain input from the upstream device |
| sdo | output | 1 | Serial data output |

## Verification
The hardest case is the debounce window. A pulse that is a few clocks shorter than the selected window must leave no trace, and a level held a few clocks longer must be taken. Filtered values are only visible through an SPI read. The stimulus therefore shapes pulses of exactly `TICKS - 5` clocks and levels of `TICKS + 10` clocks, lets them settle, and only then reads, once for each of the three filter settings. Changing the data pins and the frame-size pin in the middle of a transfer covers the capture-at-select rule.

// File: rtl/dser_pkg.sv
package dser_pkg;

    localparam int NCH = 8;
    localparam int CRC_W = 5;
    localparam logic [CRC_W-1:0] CRC_POLY = 5'b10101;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'b00,
        FLT_SHORT = 2'b01,
        FLT_MED   = 2'b10,
        FLT_LONG  = 2'b11
    } flt_sel_e;

    // Serial CRC over one byte, MSB first, zero seed.
    function automatic logic [CRC_W-1:0] crc5_byte(input logic [NCH-1:0] data);
        logic [CRC_W-1:0] c;
        logic             fb;
        c = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            fb = c[CRC_W-1] ^ data[i];
            c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
        end
        return c;
    endfunction

endpackage

// File: rtl/dser_sync.sv
module dser_sync #(
    parameter int              W   = 1,
    parameter logic [W-1:0]    RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.s1 <= RST;
            st_q.s2 <= RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.s2;
endmodule

// File: rtl/dser_debounce.sv
module dser_debounce #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          raw,
    input  logic [CW-1:0] limit,
    output logic          filt
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          out;
    } st_t;

    st_t          st_d, st_q;
    logic [CW:0]  cnt_nxt;

    always_comb begin
        st_d    = st_q;
        cnt_nxt = {1'b0, st_q.cnt} + {{CW{1'b0}}, 1'b1};
        if (raw == st_q.out) begin
            st_d.cnt = '0;
        end else if (cnt_nxt >= {1'b0, limit}) begin
            st_d.out = raw;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = cnt_nxt[CW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign filt = st_q.out;
endmodule

// File: rtl/dser_shifter.sv
module dser_shifter #(
    parameter int NCH = 8,
    localparam int WW = 2 * NCH
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cs_n_s,
    input  logic           sclk_s,
    input  logic           sdi_s,
    input  logic           wide_in,
    input  logic [NCH-1:0] data_in,
    input  logic [NCH-1:0] status_in,
    output logic           sdo,
    output logic           load_evt,
    output logic           shift_evt,
    output logic           wide_lat,
    output logic [WW-1:0]  sr_word
);
    typedef struct packed {
        logic          cs_prev;
        logic          sclk_prev;
        logic          sdi_hold;
        logic          wide;
        logic [WW-1:0] sr;
    } st_t;

    st_t  st_d, st_q;
    logic rise_evt;

    always_comb begin
        st_d          = st_q;
        st_d.cs_prev  = cs_n_s;
        st_d.sclk_prev = sclk_s;
        load_evt      = st_q.cs_prev & ~cs_n_s;
        rise_evt      = ~load_evt & ~cs_n_s & ~st_q.sclk_prev & sclk_s;
        shift_evt     = ~load_evt & ~cs_n_s & st_q.sclk_prev & ~sclk_s;
        if (load_evt) begin
            st_d.wide = wide_in;
            st_d.sr   = wide_in ? {data_in, status_in} : {{NCH{1'b0}}, data_in};
        end else begin
            if (rise_evt) begin
                st_d.sdi_hold = sdi_s;
            end
            if (shift_evt) begin
                st_d.sr = {st_q.sr[WW-2:0], st_q.sdi_hold};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cs_prev   <= 1'b1;
            st_q.sclk_prev <= 1'b0;
            st_q.sdi_hold  <= 1'b0;
            st_q.wide      <= 1'b0;
            st_q.sr        <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdo      = st_q.wide ? st_q.sr[WW-1] : st_q.sr[NCH-1];
    assign wide_lat = st_q.wide;
    assign sr_word  = st_q.sr;
endmodule

// File: rtl/dser_top.sv
module dser_top
    import dser_pkg::*;
#(
    parameter int TICKS_SHORT = 25,
    parameter int TICKS_MED   = 750,
    parameter int TICKS_LONG  = 3000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] in_pins,
    input  logic [1:0] flt_sel,
    input  logic       word_wide,
    input  logic       ot_alarm,
    input  logic       uv_alarm_n,
    input  logic       uv_warn_n,
    input  logic       cs_n,
    input  logic       sclk,
    input  logic       sdi,
    output logic       sdo
);
    localparam int CW   = $clog2(TICKS_LONG + 1);
    localparam int WW   = 2 * NCH;
    localparam int SW   = NCH + 9;
    localparam logic [SW-1:0] SYNC_RST = {1'b1, {(SW-1){1'b0}}};

    logic [SW-1:0]  sync_in, sync_out;
    logic           cs_n_s, sclk_s, sdi_s, wide_s, ot_s, uva_s, uvw_s;
    logic [1:0]     sel_s;
    logic [NCH-1:0] din_s;
    logic [NCH-1:0] filt;
    logic [CW-1:0]  limit;
    logic [NCH-1:0] status_byte;
    logic           load_evt, shift_evt, wide_lat;
    logic [WW-1:0]  sr_word;

    assign sync_in = {cs_n, sclk, sdi, word_wide, ot_alarm, uv_alarm_n,
                      uv_warn_n, flt_sel, in_pins};

    dser_sync #(.W(SW), .RST(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sync_in),
        .q     (sync_out)
    );

    assign {cs_n_s, sclk_s, sdi_s, wide_s, ot_s, uva_s, uvw_s, sel_s, din_s} = sync_out;

    always_comb begin
        unique case (flt_sel_e'(sel_s))
            FLT_NONE:  limit = CW'(1);
            FLT_SHORT: limit = CW'(TICKS_SHORT);
            FLT_MED:   limit = CW'(TICKS_MED);
            default:   limit = CW'(TICKS_LONG);
        endcase
    end

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        dser_debounce #(.CW(CW)) u_db (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (din_s[g]),
            .limit (limit),
            .filt  (filt[g])
        );
    end

    assign status_byte = {crc5_byte(filt), uva_s, ot_s, uvw_s};

    dser_shifter #(.NCH(NCH)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_s    (cs_n_s),
        .sclk_s    (sclk_s),
        .sdi_s     (sdi_s),
        .wide_in   (wide_s),
        .data_in   (filt),
        .status_in (status_byte),
        .sdo       (sdo),
        .load_evt  (load_evt),
        .shift_evt (shift_evt),
        .wide_lat  (wide_lat),
        .sr_word   (sr_word)
    );
endmodule

// File: rtl/dser_checker.sv
module dser_checker #(
    parameter int NCH = 8,
    localparam int WW = 2 * NCH
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cs_n_s,
    input logic           load_evt,
    input logic           shift_evt,
    input logic           wide_lat,
    input logic [WW-1:0]  sr_word,
    input logic [NCH-1:0] din_s,
    input logic [1:0]     sel_s,
    input logic [NCH-1:0] filt
);
    AST_FILT_ONLY_ON_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ((filt ^ $past(filt)) & ~($past(din_s) ^ $past(filt))) == '0); // R8

    AST_BYPASS_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sel_s) == 2'b00) |-> (filt == $past(din_s))); // R7

    AST_IDLE_HOLDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> $stable(sr_word)); // R11

    AST_MODE_HELD_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_s && !load_evt) |=> $stable(wide_lat)); // R11

    AST_SHIFT_MOVES_UP: assert property (@(posedge clk) disable iff (!rst_n)
        shift_evt |=> (sr_word[WW-1:1] == $past(sr_word[WW-2:0]))); // R6
endmodule

bind dser_top dser_checker #(.NCH(dser_pkg::NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n_s    (cs_n_s),
    .load_evt  (load_evt),
    .shift_evt (shift_evt),
    .wide_lat  (wide_lat),
    .sr_word   (sr_word),
    .din_s     (din_s),
    .sel_s     (sel_s),
    .filt      (filt)
);

// File: tb/dser_top_tb.sv
`timescale 1ns/1ps
module dser_top_tb;
    localparam int TS = 25;
    localparam int TM = 750;
    localparam int TL = 3000;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_pins = 8'h00;
    logic [1:0] flt_sel = 2'b00;
    logic       word_wide = 1'b0;
    logic       ot_alarm = 1'b0;
    logic       uv_alarm_n = 1'b1;
    logic       uv_warn_n = 1'b1;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       sdi = 1'b0;
    logic       sdo;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    logic [31:0] exp_v[$];
    string       exp_tag[$];
    logic [31:0] got_v[$];

    always #2.5 clk = ~clk;

    dser_top #(.TICKS_SHORT(TS), .TICKS_MED(TM), .TICKS_LONG(TL)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_pins(in_pins), .flt_sel(flt_sel),
        .word_wide(word_wide), .ot_alarm(ot_alarm), .uv_alarm_n(uv_alarm_n),
        .uv_warn_n(uv_warn_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .sdo(sdo)
    );

    function automatic logic [4:0] ref_crc(input logic [7:0] d);
        logic [7:0] x;
        x = d;
        for (int k = 0; k < 8; k++) x = x[7] ? ((x << 1) ^ 8'hA8) : (x << 1);
        return x[7:3];
    endfunction

    function automatic logic [15:0] ref_wide(input logic [7:0] d, input logic uva,
                                             input logic ot, input logic uvw);
        return {d, ref_crc(d), uva, ot, uvw};
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_exp(input logic [31:0] v, input string tag);
        exp_v.push_back(v);
        exp_tag.push_back(tag);
    endtask

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] expv);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    // Driver: one SPI transfer; optional pin changes at bit index mid_idx.
    task automatic xfer(input int nbits, input logic [31:0] pat, input int mid_idx,
                        input logic [7:0] mid_din, input logic mid_wide);
        logic [31:0] got;
        got = '0;
        cs_n = 1'b0;
        tick(HALF);
        for (int i = 0; i < nbits; i++) begin
            if (i == mid_idx) begin
                in_pins   = mid_din;
                word_wide = mid_wide;
            end
            sdi  = pat[nbits-1-i];
            got  = {got[30:0], sdo};
            sclk = 1'b1;
            tick(HALF);
            sclk = 1'b0;
            tick(HALF);
        end
        cs_n = 1'b1;
        sdi  = 1'b0;
        tick(HALF);
        got_v.push_back(got);
    endtask

    task automatic read(input int nbits);
        xfer(nbits, 32'h0, -1, 8'h00, 1'b0);
    endtask

    // Monitor: pops and compares as results arrive.
    initial begin
        forever begin
            @(negedge clk);
            while (got_v.size() > 0 && exp_v.size() > 0) begin
                logic [31:0] g, e;
                string t;
                g = got_v.pop_front();
                e = exp_v.pop_front();
                t = exp_tag.pop_front();
                check(g == e, t, g, e);
            end
        end
    end

    initial begin
        #750000;
        if (!finished) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        tick(10);
        check(sdo == 1'b0, "R1 sdo after reset", {31'b0, sdo}, 32'h0);
        rst_n = 1'b1;
        tick(5);
        check(sdo == 1'b0, "R1 sdo out of reset", {31'b0, sdo}, 32'h0);

        // R1: first read returns zero
        push_exp(32'h00, "R1 reset data");
        read(8);

        // R7 / R2: bypass, narrow frames
        in_pins = 8'hA5; tick(6);
        push_exp(32'hA5, "R2 R7 narrow A5");
        read(8);
        in_pins = 8'h3C; tick(6);
        push_exp(32'h3C, "R2 R7 narrow 3C");
        read(8);

        // R3 / R4 / R5: wide frames with varied status pins
        word_wide = 1'b1;
        in_pins = 8'h96; tick(6);
        push_exp({16'h0, ref_wide(8'h96, 1'b1, 1'b0, 1'b1)}, "R3 R5 wide 96");
        read(16);
        ot_alarm = 1'b1; uv_alarm_n = 1'b0; uv_warn_n = 1'b0;
        in_pins = 8'hFF; tick(6);
        push_exp({16'h0, ref_wide(8'hFF, 1'b0, 1'b1, 1'b0)}, "R4 status FF");
        read(16);
        ot_alarm = 1'b0; uv_alarm_n = 1'b1; uv_warn_n = 1'b0;
        in_pins = 8'h00; tick(6);
        push_exp({16'h0, ref_wide(8'h00, 1'b1, 1'b0, 1'b0)}, "R4 R5 status 00");
        read(16);
        ot_alarm = 1'b1; uv_alarm_n = 1'b1; uv_warn_n = 1'b1;
        in_pins = 8'h01; tick(6);
        push_exp({16'h0, ref_wide(8'h01, 1'b1, 1'b1, 1'b1)}, "R5 crc 01");
        read(16);
        ot_alarm = 1'b0;

        // R6: chaining, wide then narrow
        in_pins = 8'h4B; tick(6);
        push_exp({ref_wide(8'h4B, 1'b1, 1'b0, 1'b1), 16'hBEEF}, "R6 chain wide");
        xfer(32, {16'hBEEF, 16'h1234}, -1, 8'h00, 1'b0);
        word_wide = 1'b0; tick(6);
        push_exp({16'h0, 8'h4B, 8'hC6}, "R6 chain narrow");
        xfer(16, {8'hC6, 8'h39}, -1, 8'h00, 1'b0);

        // R11: pins change mid-transfer
        word_wide = 1'b1; in_pins = 8'h5A; tick(6);
        push_exp({16'h0, ref_wide(8'h5A, 1'b1, 1'b0, 1'b1)}, "R11 mid change");
        xfer(16, 32'h0, 4, 8'hC3, 1'b0);
        tick(6);
        push_exp(32'hC3, "R11 next frame");
        read(8);

        // R8: short filter
        in_pins = 8'h00; tick(6);
        flt_sel = 2'b01; tick(4);
        in_pins = 8'hFF; tick(TS - 5);
        in_pins = 8'h00; tick(TS + 10);
        push_exp(32'h00, "R8 short pulse ignored");
        read(8);
        in_pins = 8'h0F; tick(TS + 10);
        push_exp(32'h0F, "R8 short held taken");
        read(8);

        // R9: medium filter
        flt_sel = 2'b10; tick(4);
        in_pins = 8'hF0; tick(TM - 5);
        in_pins = 8'h0F; tick(TM + 10);
        push_exp(32'h0F, "R9 medium pulse ignored");
        read(8);
        in_pins = 8'h81; tick(TM + 10);
        push_exp(32'h81, "R9 medium held taken");
        read(8);

        // R10: long filter
        flt_sel = 2'b11; tick(4);
        in_pins = 8'h7E; tick(TL - 5);
        in_pins = 8'h81; tick(TL + 10);
        push_exp(32'h81, "R10 long pulse ignored");
        read(8);
        in_pins = 8'h24; tick(TL + 10);
        push_exp(32'h24, "R10 long held taken");
        read(8);

        tick(20);
        check(exp_v.size() == 0, "ALL scoreboard drained", exp_v.size(), 32'h0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule